// File: doc/BRIEF.md
# Programmable peripheral clock-enable divider

This block produces a timing reference for peripheral logic from the processor clock. It does not gate or generate a second clock. It emits a clock-enable pulse, one processor cycle wide, at a sub-rate chosen by a 2-bit ratio setting. Peripherals sample `pclk_en` and advance only in the cycles where it is high. At the full rate the enable stays high continuously.

The ratio setting is written through a synchronous port. It can be read back at any time. The code mapping does not follow the size of the ratio: code 2'b01 selects the full rate, code 2'b10 selects half rate, and code 2'b00 selects quarter rate. Quarter rate is also the value after reset. Code 2'b11 is reserved. A write of that code is dropped without any effect.

A written code first goes to a pending holder. It becomes active only at the next enable pulse, so the pulse spacing changes cleanly from one ratio to the next. The read port always shows the active code.

Top module: `pclk_ratio_div`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rd_code` is 2'b00 and `pclk_en` is 0. The first pulse appears after the fourth rising edge following the release of reset.
- R2: While the active code is 2'b00, `pclk_en` is high for one cycle in every four and low in the other three.
- R3: While the active code is 2'b01, `pclk_en` is high in every cycle.
- R4: While the active code is 2'b10, `pclk_en` alternates high and low, one cycle each.
- R5: A write of code 2'b11 has no effect. The active code, the pending code and the pulse spacing all stay as they were.
- R6: A valid write does not change `rd_code` right away. `rd_code` changes only on the clock edge that also raises the enable pulse for the next boundary.
- R7: After a ratio change, the first interval from the boundary pulse to the next pulse equals the new ratio. The phase restarts from zero at the boundary.
- R8: `rd_code` returns the active code and never shows 2'b11.
- R9: If several valid writes arrive between two boundaries, the last of them is the one that becomes active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the ratio code |
| wr_code | input | 2 | Ratio code to write (00 quarter, 01 full, 10 half, 11 reserved) |
| rd_code | output | 2 | Currently active ratio code |
| pclk_en | output | 1 | Registered one-cycle peripheral clock enable |

## Verification
The hardest cases are writes that arrive in the same cycle as a boundary pulse, and several writes, including reserved ones, that arrive between two boundaries. In both cases the pending and active codes differ, which the ports do not show directly. Directed sequences place writes just after a known pulse to set up these cases. A long run of random writes on random cycles then covers every ratio-to-ratio handover, both at and between boundaries. A behavioural countdown model checks `pclk_en` and `rd_code` on every clock.

// File: rtl/pclkdiv_pkg.sv
package pclkdiv_pkg;
  localparam int CODE_W    = 2;
  localparam int MAX_RATIO = 4;
  localparam int CNT_W     = $clog2(MAX_RATIO);

  typedef enum logic [CODE_W-1:0] {
    RATE_QUARTER = 2'b00,
    RATE_FULL    = 2'b01,
    RATE_HALF    = 2'b10,
    RATE_RSVD    = 2'b11
  } rate_code_e;

  // Terminal phase value (ratio minus one) for a code
  function automatic logic [CNT_W-1:0] terminal_of(input rate_code_e c);
    case (c)
      RATE_FULL: terminal_of = CNT_W'(0);
      RATE_HALF: terminal_of = CNT_W'(1);
      default:   terminal_of = CNT_W'(MAX_RATIO - 1);
    endcase
  endfunction
endpackage

// File: rtl/pclkdiv_ratio_reg.sv
module pclkdiv_ratio_reg
  import pclkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              boundary,
  output rate_code_e        active_code,
  output logic [CNT_W-1:0]  terminal
);
  rate_code_e pend_code;
  logic       wr_ok;

  assign wr_ok = wr_en && (rate_code_e'(wr_code) != RATE_RSVD);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_code   <= RATE_QUARTER;
      active_code <= RATE_QUARTER;
    end else begin
      if (wr_ok) pend_code <= rate_code_e'(wr_code);
      if (boundary) active_code <= pend_code;
    end
  end

  assign terminal = terminal_of(active_code);

  AST_RSVD_KEEPS_PENDING: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_code == 2'b11) |=> $stable(pend_code)); // R5
  AST_ACTIVE_NOT_RSVD: assert property (@(posedge clk) disable iff (rst)
    active_code != RATE_RSVD); // R8
  AST_ACTIVE_MOVES_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(active_code)); // R6
endmodule

// File: rtl/pclkdiv_phase_gen.sv
module pclkdiv_phase_gen
  import pclkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] terminal,
  output logic             boundary,
  output logic             pulse
);
  logic [CNT_W-1:0] phase;

  assign boundary = (phase == terminal);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= boundary;
      if (boundary) phase <= '0;
      else          phase <= phase + CNT_W'(1);
    end
  end

  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (rst)
    boundary |=> (phase == '0)); // R7
endmodule

// File: rtl/pclk_ratio_div.sv
module pclk_ratio_div
  import pclkdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_code,
  output logic [1:0] rd_code,
  output logic       pclk_en
);
  rate_code_e       active_code;
  logic [CNT_W-1:0] terminal;
  logic             boundary;

  pclkdiv_ratio_reg u_reg (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_code     (wr_code),
    .boundary    (boundary),
    .active_code (active_code),
    .terminal    (terminal)
  );

  pclkdiv_phase_gen u_phase (
    .clk      (clk),
    .rst      (rst),
    .terminal (terminal),
    .boundary (boundary),
    .pulse    (pclk_en)
  );

  assign rd_code = active_code;

  AST_RD_NEVER_RSVD: assert property (@(posedge clk) disable iff (rst)
    rd_code != 2'b11); // R8
  AST_CODE_CHANGE_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
    (rd_code != $past(rd_code)) |-> pclk_en); // R6
  AST_FULL_RATE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (rd_code == 2'b01) |-> pclk_en); // R3
  AST_QUARTER_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (rd_code == 2'b00 && pclk_en) |=> !pclk_en); // R2
  AST_HALF_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    (rd_code == 2'b10 && $past(rd_code) == 2'b10 && !pclk_en) |=> pclk_en); // R4
endmodule

// File: tb/pclk_ratio_div_tb.sv
module pclk_ratio_div_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_code = 2'b00;
  logic [1:0] rd_code;
  logic       pclk_en;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit cmp_on = 0;

  // behavioural model state
  int m_act = 0, m_pend = 0, m_left = 4;
  bit m_en = 0;

  always #10 clk = ~clk;

  pclk_ratio_div u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code),
    .rd_code(rd_code), .pclk_en(pclk_en)
  );

  function automatic int period_of(input int c);
    if (c == 1) return 1;
    if (c == 2) return 2;
    return 4;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0; m_pend = 0; m_left = 4; m_en = 0;
    end else begin
      m_left = m_left - 1;
      if (m_left == 0) begin
        m_en = 1;
        m_act = m_pend;
        m_left = period_of(m_act);
      end else begin
        m_en = 0;
      end
      if (wr_en && wr_code != 2'b11) m_pend = int'(wr_code);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check("R7 enable vs model", int'(pclk_en), int'(m_en));
      check("R8 rd_code vs model", int'(rd_code), m_act);
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] c);
    wr_en = 1'b1; wr_code = c;
    step();
    wr_en = 1'b0;
  endtask

  task automatic wait_pulse();
    for (int i = 0; i < 8; i++) begin
      if (pclk_en) break;
      step();
    end
  endtask

  function automatic int count_pulses_dummy(); return 0; endfunction

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 rd_code in reset", int'(rd_code), 0);
    check("R1 enable in reset", int'(pclk_en), 0);
    rst = 1'b0;
    cmp_on = 1;
    step();
    check("R1 enable edge1", int'(pclk_en), 0);
    step();
    check("R1 enable edge2", int'(pclk_en), 0);
    step();
    check("R1 enable edge3", int'(pclk_en), 0);
    step();
    check("R1 first pulse edge4", int'(pclk_en), 1);

    // R2: quarter rate, 16 cycles -> 4 pulses
    n = 0;
    for (int i = 0; i < 16; i++) begin step(); n += int'(pclk_en); end
    check("R2 pulses in 16 cycles", n, 4);

    // R5: reserved write ignored
    wr(2'b11);
    n = 0;
    for (int i = 0; i < 12; i++) begin
      step(); n += int'(pclk_en);
      check("R5 rd_code after reserved write", int'(rd_code), 0);
    end
    check("R5 spacing kept after reserved write", n, 3);

    // R6 / R3: switch to full rate
    wait_pulse();
    wr(2'b01);
    check("R6 code not yet active", int'(rd_code), 0);
    wait_pulse();
    check("R6 code active at pulse", int'(rd_code), 1);
    for (int i = 0; i < 8; i++) begin
      step();
      check("R3 enable held high", int'(pclk_en), 1);
    end

    // R4 / R7: half rate
    wr(2'b10);
    wait_pulse();
    while (rd_code != 2'b10) step();
    check("R7 boundary pulse for half rate", int'(pclk_en), 1);
    step();
    check("R7 low after boundary", int'(pclk_en), 0);
    step();
    check("R7 next pulse after 2", int'(pclk_en), 1);
    n = 0;
    for (int i = 0; i < 8; i++) begin step(); n += int'(pclk_en); end
    check("R4 pulses in 8 cycles", n, 4);

    // back to quarter, then R9 last write wins
    wr(2'b00);
    for (int i = 0; i < 6; i++) step();
    while (!(pclk_en && rd_code == 2'b00)) step();
    wr(2'b10);
    wr(2'b11);
    wr(2'b01);
    check("R9 still quarter before boundary", int'(rd_code), 0);
    wait_pulse();
    check("R9 last valid write active", int'(rd_code), 1);

    // random stress with model compare
    for (int i = 0; i < 3000; i++) begin
      wr_en = ($urandom_range(0, 3) == 0);
      wr_code = 2'($urandom_range(0, 3));
      step();
    end
    wr_en = 1'b0;
    step();
    cmp_on = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule